// File: doc/BRIEF.md
# Key-evolving modular power unit

This block keeps a secret session key and, when asked, replaces it with the next key in a one-way chain. Each step raises the current key to the eighth power, multiplies by a secret multiplier and reduces modulo a secret odd composite modulus. The key, the multiplier and the modulus are written once at personalisation through a shared data bus and three load strobes. After that, each pulse on the advance strobe moves the chain forward by one key.

All arithmetic runs on one bit-serial modular multiplier. A step is three squarings and then one product with the multiplier. The step time does not depend on the data. Only a sparse quarter of the evolved key leaves the block as key material: every fourth bit, starting at bit 0. The full key stays visible on its own port for the personalisation check.

Top module: `kev_top`

## Requirements
- R1: One accepted advance replaces key_out with (mul · key_out^8) mod n, computed over the loaded multiplier and the accepted modulus.
- R2: Advances issued back to back chain, each step starting from the key left by the previous one.
- R3: done rises exactly 4·W+4 clock edges after the edge that accepts adv, for every key, multiplier and modulus.
- R4: mat_out bit j equals key_out bit 4·j for j = 0 … W/4−1. It follows key_out on a key load and on every commit.
- R5: done is high for one cycle, in the first cycle that key_out shows the new key. The working copies of the old key inside the multiplier are cleared at that edge.
- R6: adv and every load strobe are ignored while a step runs. The step's result and timing are unchanged, and only one done follows.
- R7: adv has no effect while no modulus is accepted: after reset, and after any key or multiplier load until a modulus is accepted again.
- R8: A modulus load is accepted only if the value is odd and strictly greater than both the stored key and the stored multiplier. Acceptance clears err. A rejected load sets err and keeps the previously accepted modulus in use.
- R9: When several load strobes are high in one idle cycle, only the highest one takes effect: key first, then multiplier, then modulus. adv is ignored in any cycle that carries a load strobe.
- R10: After reset key_out, mat_out, done and err are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_ld | input | 1 | Write ld_data to the key |
| mul_ld | input | 1 | Write ld_data to the multiplier |
| mod_ld | input | 1 | Offer ld_data as modulus (checked) |
| ld_data | input | W | Shared load value |
| adv | input | 1 | Request one evolution step |
| key_out | output | W | Current key |
| mat_out | output | W/4 | Key material, every fourth key bit |
| done | output | 1 | One-cycle pulse when a new key is committed |
| err | output | 1 | Last modulus offer was rejected |

## Verification
The hardest case to reach is a strobe that lands in the middle of a running step. The stimulus gets there by raising adv to start a step and then, a few cycles later, raising adv and a key load together. The bench then checks that the step's latency and result match a single advance and that no second done follows. A second hard case is a rejected modulus that must leave the old one in force. This case is invisible on err alone, so the bench follows every rejection with an advance and compares the result against the earlier modulus. The bulk of the stimulus sweeps every key below three 8-bit moduli.

// File: rtl/kev_pkg.sv
package kev_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } kev_state_t;

  localparam int unsigned OPS_PER_STEP = 4;
endpackage

// File: rtl/kev_modchk.sv
module kev_modchk #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] cand,
  input  logic [W-1:0] key,
  input  logic [W-1:0] mul,
  output logic         ok
);
  always_comb begin
    ok = cand[0] && (cand > key) && (cand > mul);
  end
endmodule

// File: rtl/kev_modmul.sv
module kev_modmul #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic [W-1:0] n,
  output logic         rdy,
  output logic [W-1:0] prod
);
  localparam int unsigned CW = $clog2(W + 1);

  logic [W-1:0]  acc, xs, ys;
  logic [CW-1:0] cnt;
  logic          running, rdy_q;
  logic [W:0]    dbl, sum;
  logic [W-1:0]  dbl_red, sum_red;

  always_comb begin
    dbl     = {acc, 1'b0};
    dbl_red = (dbl >= {1'b0, n}) ? W'(dbl - {1'b0, n}) : dbl[W-1:0];
    sum     = {1'b0, dbl_red} + (xs[W-1] ? {1'b0, ys} : '0);
    sum_red = (sum >= {1'b0, n}) ? W'(sum - {1'b0, n}) : sum[W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc     <= '0;
      xs      <= '0;
      ys      <= '0;
      cnt     <= '0;
      running <= 1'b0;
      rdy_q   <= 1'b0;
    end else begin
      rdy_q <= 1'b0;
      if (start) begin
        acc     <= '0;
        xs      <= x;
        ys      <= y;
        cnt     <= CW'(W);
        running <= 1'b1;
      end else if (running) begin
        acc <= sum_red;
        xs  <= {xs[W-2:0], 1'b0};
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          running <= 1'b0;
          rdy_q   <= 1'b1;
        end
      end else if (rdy_q) begin
        acc <= '0;
        xs  <= '0;
        ys  <= '0;
      end
    end
  end

  assign rdy  = rdy_q;
  assign prod = acc;

  assert_acc_reduced_R1: assert property (@(posedge clk) disable iff (rst)
    running |-> (acc < n));

  assert_scrub_R5: assert property (@(posedge clk) disable iff (rst)
    (rdy_q && !start) |=> (acc == '0 && ys == '0 && xs == '0));
endmodule

// File: rtl/kev_ctl.sv
module kev_ctl
  import kev_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic go,
  input  logic rdy,
  output logic busy,
  output logic start,
  output logic commit,
  output logic x_from_key,
  output logic y_from_mul
);
  kev_state_t  state;
  logic [1:0]  phase;
  localparam logic [1:0] LAST = 2'(OPS_PER_STEP - 1);

  always_comb begin
    busy       = (state == ST_RUN);
    x_from_key = (state == ST_IDLE);
    y_from_mul = rdy && (phase == LAST - 2'd1);
    commit     = busy && rdy && (phase == LAST);
    start      = (!busy && go) || (busy && rdy && (phase != LAST));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      phase <= '0;
    end else if (state == ST_IDLE) begin
      if (go) begin
        state <= ST_RUN;
        phase <= '0;
      end
    end else if (rdy) begin
      if (phase == LAST) begin
        state <= ST_IDLE;
        phase <= '0;
      end else begin
        phase <= phase + 2'd1;
      end
    end
  end

  assert_phase_idle_R3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> (phase == 2'd0));
endmodule

// File: rtl/kev_top.sv
module kev_top #(
  parameter int unsigned W = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           key_ld,
  input  logic           mul_ld,
  input  logic           mod_ld,
  input  logic [W-1:0]   ld_data,
  input  logic           adv,
  output logic [W-1:0]   key_out,
  output logic [W/4-1:0] mat_out,
  output logic           done,
  output logic           err
);
  localparam int unsigned MW = W / 4;

  logic [W-1:0]  key_r, mul_r, n_r, key_d, prod, op_x, op_y;
  logic [MW-1:0] mat_d, mat_r;
  logic          mod_ok, err_r, done_r;
  logic          busy, start, commit, sel_x_key, sel_y_mul, rdy;
  logic          idle, ld_any, go, cand_ok;
  logic          take_key, take_mul, take_mod;

  always_comb begin
    idle     = !busy;
    ld_any   = key_ld || mul_ld || mod_ld;
    go       = idle && adv && mod_ok && !ld_any;
    take_key = idle && key_ld;
    take_mul = idle && !key_ld && mul_ld;
    take_mod = idle && !key_ld && !mul_ld && mod_ld;
    op_x     = sel_x_key ? key_r : prod;
    op_y     = sel_y_mul ? mul_r : op_x;
  end

  kev_ctl u_ctl (
    .clk        (clk),
    .rst        (rst),
    .go         (go),
    .rdy        (rdy),
    .busy       (busy),
    .start      (start),
    .commit     (commit),
    .x_from_key (sel_x_key),
    .y_from_mul (sel_y_mul)
  );

  kev_modmul #(.W(W)) u_mm (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .x     (op_x),
    .y     (op_y),
    .n     (n_r),
    .rdy   (rdy),
    .prod  (prod)
  );

  kev_modchk #(.W(W)) u_chk (
    .cand (ld_data),
    .key  (key_r),
    .mul  (mul_r),
    .ok   (cand_ok)
  );

  always_comb begin
    key_d = key_r;
    if (commit)        key_d = prod;
    else if (take_key) key_d = ld_data;
  end

  for (genvar j = 0; j < MW; j++) begin : g_tap
    assign mat_d[j] = key_d[4*j];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      key_r  <= '0;
      mul_r  <= '0;
      n_r    <= '0;
      mat_r  <= '0;
      mod_ok <= 1'b0;
      err_r  <= 1'b0;
      done_r <= 1'b0;
    end else begin
      key_r  <= key_d;
      mat_r  <= mat_d;
      done_r <= commit;
      if (take_mul) mul_r <= ld_data;
      if (take_key || take_mul) mod_ok <= 1'b0;
      if (take_mod) begin
        if (cand_ok) begin
          n_r    <= ld_data;
          mod_ok <= 1'b1;
          err_r  <= 1'b0;
        end else begin
          err_r  <= 1'b1;
        end
      end
    end
  end

  assign key_out = key_r;
  assign mat_out = mat_r;
  assign done    = done_r;
  assign err     = err_r;

  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    done_r |=> !done_r);

  assert_key_hold_busy_R6: assert property (@(posedge clk) disable iff (rst)
    (busy && !commit) |=> $stable(key_r));

  assert_no_run_without_mod_R7: assert property (@(posedge clk) disable iff (rst)
    (!busy && !mod_ok) |=> !busy);

  assert_mod_valid_R8: assert property (@(posedge clk) disable iff (rst)
    mod_ok |-> (n_r[0] && (n_r > key_r) && (n_r > mul_r)));

  assert_reject_keeps_mod_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(err_r) |-> $stable(n_r));
endmodule

// File: tb/sim_kev_top.sv
module sim_kev_top;
  localparam int W   = 8;
  localparam int MW  = W / 4;
  localparam int LAT = 4 * W + 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         key_ld = 1'b0, mul_ld = 1'b0, mod_ld = 1'b0, adv = 1'b0;
  logic [W-1:0] ld_data = '0;
  logic [W-1:0] key_out;
  logic [MW-1:0] mat_out;
  logic         done, err;

  int nvec = 0;
  int nfail = 0;

  always #10 clk = ~clk;

  kev_top #(.W(W)) u0 (
    .clk(clk), .rst(rst), .key_ld(key_ld), .mul_ld(mul_ld), .mod_ld(mod_ld),
    .ld_data(ld_data), .adv(adv), .key_out(key_out), .mat_out(mat_out),
    .done(done), .err(err)
  );

  function automatic int evolve(input int k, input int a, input int n);
    int t = k;
    for (int i = 0; i < 3; i++) t = (t * t) % n;
    return (a * t) % n;
  endfunction

  function automatic int taps(input int k);
    int r = 0;
    for (int j = 0; j < MW; j++) r |= ((k >> (4 * j)) & 1) << j;
    return r;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load(input int which, input int v);
    @(negedge clk);
    ld_data = W'(v);
    key_ld  = (which == 0);
    mul_ld  = (which == 1);
    mod_ld  = (which == 2);
    @(negedge clk);
    key_ld = 1'b0; mul_ld = 1'b0; mod_ld = 1'b0;
  endtask

  task automatic run_adv(output int lat);
    @(negedge clk) adv = 1'b1;
    @(negedge clk) adv = 1'b0;
    lat = 0;
    while (!done && lat < LAT + 20) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic count_dones(input int cycles, output int nd);
    nd = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (done) nd++;
    end
  endtask

  task automatic one_step(input string tag, input int k, input int a, input int n);
    int lat;
    run_adv(lat);
    check({tag, " R3 latency"}, lat, LAT);
    check({tag, " R1 key"}, int'(key_out), evolve(k, a, n));
    check({tag, " R4 material"}, int'(mat_out), taps(evolve(k, a, n)));
    @(negedge clk);
    check({tag, " R5 done width"}, int'(done), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    int nd, lat, k, a, exp_k;
    int mods[3] = '{221, 143, 255};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check("R10 key", int'(key_out), 0);
    check("R10 mat", int'(mat_out), 0);
    check("R10 done", int'(done), 0);
    check("R10 err", int'(err), 0);

    // R7: advance with no modulus accepted
    @(negedge clk) adv = 1'b1;
    @(negedge clk) adv = 1'b0;
    count_dones(LAT + 8, nd);
    check("R7 no done after reset", nd, 0);
    check("R7 key unchanged", int'(key_out), 0);

    // R1 R3 R4 R5 R8: sweep every key below three moduli
    foreach (mods[m]) begin
      for (int kk = 0; kk < mods[m]; kk++) begin
        a = (kk * 37 + 11) % mods[m];
        load(0, kk);
        check("R4 material on load", int'(mat_out), taps(kk));
        load(1, a);
        load(2, mods[m]);
        check("R8 accept", int'(err), 0);
        one_step("sweep", kk, a, mods[m]);
      end
    end

    // R2: chained advances
    load(0, 5); load(1, 7); load(2, 221);
    k = 5;
    for (int i = 0; i < 10; i++) begin
      one_step("R2 chain", k, 7, 221);
      k = evolve(k, 7, 221);
    end

    // R7: key load withdraws the modulus
    load(0, 9);
    @(negedge clk) adv = 1'b1;
    @(negedge clk) adv = 1'b0;
    count_dones(LAT + 8, nd);
    check("R7 no done after key load", nd, 0);
    check("R7 key kept", int'(key_out), 9);

    // R8: rejections keep the previous modulus
    load(0, 3); load(1, 101); load(2, 221);
    load(2, 220);
    check("R8 even rejected", int'(err), 1);
    load(2, 99);
    check("R8 below mul rejected", int'(err), 1);
    load(2, 101);
    check("R8 equal to mul rejected", int'(err), 1);
    one_step("R8 old modulus in use", 3, 101, 221);
    k = evolve(3, 101, 221);
    if (k < 103) begin
      load(2, 103);
      check("R8 accept clears err", int'(err), 0);
      one_step("R8 new modulus", k, 101, 103);
    end else begin
      load(2, 2 * k + 1 > 255 ? 255 : 2 * k + 1);
      check("R8 accept clears err", int'(err), 0);
    end
    load(0, 200); load(1, 9); load(2, 221);
    load(2, 199);
    check("R8 below key rejected", int'(err), 1);
    one_step("R8 keeps 221", 200, 9, 221);

    // R6: strobes during a running step are ignored
    load(0, 5); load(1, 7); load(2, 221);
    exp_k = evolve(5, 7, 221);
    @(negedge clk) adv = 1'b1;
    @(negedge clk) adv = 1'b0;
    lat = 0;
    repeat (5) begin @(negedge clk); lat++; end
    adv = 1'b1; key_ld = 1'b1; ld_data = 8'd77;
    @(negedge clk); lat++;
    adv = 1'b0; key_ld = 1'b0;
    while (!done && lat < LAT + 20) begin @(negedge clk); lat++; end
    check("R6 latency unchanged", lat, LAT);
    check("R6 result unchanged", int'(key_out), exp_k);
    count_dones(LAT + 8, nd);
    check("R6 single done", nd, 0);

    // R9: key and modulus strobes in one cycle
    @(negedge clk);
    ld_data = 8'd84; key_ld = 1'b1; mod_ld = 1'b1;
    @(negedge clk);
    key_ld = 1'b0; mod_ld = 1'b0;
    check("R9 key wins", int'(key_out), 84);
    check("R9 modulus not offered", int'(err), 0);
    @(negedge clk) adv = 1'b1;
    @(negedge clk) adv = 1'b0;
    count_dones(LAT + 8, nd);
    check("R9 modulus withdrawn", nd, 0);

    // R9: adv together with a load is ignored
    load(1, 7); load(2, 221);
    @(negedge clk) begin adv = 1'b1; mul_ld = 1'b1; ld_data = 8'd3; end
    @(negedge clk) begin adv = 1'b0; mul_ld = 1'b0; end
    count_dones(LAT + 8, nd);
    check("R9 adv with load ignored", nd, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule